// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block converts a logical address made of a segment part and an offset into a physical address. It works in one of two modes, chosen per request. In real mode the segment input is a plain paragraph number: it is multiplied by sixteen and added to a 16-bit offset, so every segment covers exactly 64 KiB from its base, and two segments may cover the same bytes.

In protected mode the segment input is a selector. Its upper thirteen bits index a small descriptor table held inside the block and loaded through a write port. A descriptor holds the following:
- a 32-bit base
- a 20-bit raw limit
- a granularity flag
- a present flag
- a type flag that separates code/data segments from system entries

The physical address is the base plus a 32-bit offset. The translation faults, and no address is produced, when any of these holds:
- the selector points past the table
- the entry is absent
- the entry is a system entry
- the offset exceeds the limit after the granularity scaling

A request is presented with a strobe. The result appears one registered cycle later, together with a valid flag and a fault code.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, outValid is 0, outFault is 0, outAddr is 0, and every descriptor entry reads as not present.
- R2: outValid is 1 in exactly the cycle after a cycle with reqValid high, and 0 otherwise. The result belongs to the request of the previous cycle.
- R3: In real mode (reqProt = 0), outAddr = reqSeg * 16 + reqOffset[15:0], zero-extended to 32 bits with no wraparound. reqOffset[31:16] is ignored, and outFault is always 0.
- R4: In protected mode (reqProt = 1) with no fault, outAddr = descriptor base + reqOffset modulo 2^32.
- R5: The descriptor index is reqSeg[15:3], and reqSeg[2:0] is ignored. An index not below NUM_DESC gives fault code 1 (selector).
- R6: An entry whose present flag is 0 gives fault code 2 (absent).
- R7: An entry whose type flag is 0 (system entry) gives fault code 3 (system).
- R8: With granularity flag 0, the limit counts bytes. An offset greater than the raw limit gives fault code 4 (limit), and an offset equal to the limit is accepted.
- R9: With granularity flag 1, the effective limit is {raw limit, 12'hFFF}. The limit check of R8 uses that value.
- R10: When several faults apply, the code reported follows the priority selector > absent > system > limit.
- R11: A faulted result drives outAddr to 0. Fault code 0 means success, and codes above 4 never appear.
- R12: A descriptor write takes effect at the clock edge where wrEn is high. A request in that same cycle is translated with the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqProt | input | 1 | 1 = protected mode, 0 = real mode |
| reqSeg | input | 16 | Segment value (real) or selector (protected) |
| reqOffset | input | 32 | Offset; only bits [15:0] are used in real mode |
| wrEn | input | 1 | Descriptor write strobe |
| wrIndex | input | IDX_W | Descriptor entry to write |
| wrBase | input | 32 | Base of the written entry |
| wrLimit | input | 20 | Raw limit of the written entry |
| wrGran | input | 1 | 1 = limit in 4 KiB units |
| wrPresent | input | 1 | Present flag |
| wrCodeData | input | 1 | 1 = code/data entry, 0 = system entry |
| outValid | output | 1 | Result valid, one cycle after reqValid |
| outAddr | output | 32 | Physical address, 0 on a fault |
| outFault | output | 3 | 0 none, 1 selector, 2 absent, 3 system, 4 limit |

## Verification
Real-mode vectors include overlapping segments and the largest segment with the largest offset, which shows that the sum carries into bit 20 and is not masked. They also set the upper offset bits, to show those bits are ignored. Protected-mode vectors place offsets at the effective limit and one past it under both granularities, which separates a byte-count limit from a page-scaled one and an inclusive compare from an exclusive one. Entries that combine several fault conditions show the priority order, and a base near the top of the space shows the wrap of the sum. A random mix of modes, selectors just inside and just past the table, and interleaved descriptor writes covers the rest, including a write in the same cycle as a request.

// File: rtl/segx_pkg.sv
package segx_pkg;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] limit;
    logic        gran;
    logic        present;
    logic        codeData;
  } seg_desc_t;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_SELECTOR = 3'd1,
    FLT_ABSENT   = 3'd2,
    FLT_SYSTEM   = 3'd3,
    FLT_LIMIT    = 3'd4
  } fault_e;

  typedef struct packed {
    logic   capture;
    logic   useProt;
    logic   zeroAddr;
    fault_e fault;
  } xlate_strobe_t;

endpackage

// File: rtl/segx_desc_table.sv
module segx_desc_table
  import segx_pkg::*;
#(
  parameter int NUM_DESC  = 8,
  parameter int IDX_W     = 3,
  parameter int SEL_IDX_W = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrIndex,
  input  seg_desc_t            wrDesc,
  input  logic [SEL_IDX_W-1:0] rdIndex,
  output logic                 rdInRange,
  output seg_desc_t            rdDesc
);

  seg_desc_t entries [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entries[g] <= '0;
      end else if (wrEn && (wrIndex == IDX_W'(g))) begin
        entries[g] <= wrDesc;
      end
    end
  end

  assign rdInRange = (rdIndex < SEL_IDX_W'(NUM_DESC));

  always_comb begin
    rdDesc = '0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (rdIndex == SEL_IDX_W'(i)) begin
        rdDesc = entries[i];
      end
    end
  end

endmodule

// File: rtl/segx_ctrl.sv
module segx_ctrl
  import segx_pkg::*;
(
  input  logic          reqValid,
  input  logic          reqProt,
  input  logic          selInRange,
  input  logic          descPresent,
  input  logic          descCodeData,
  input  logic          overLimit,
  output xlate_strobe_t strobe
);

  fault_e faultSel;

  always_comb begin
    faultSel = FLT_NONE;
    if (reqProt) begin
      if (!selInRange) begin
        faultSel = FLT_SELECTOR;
      end else if (!descPresent) begin
        faultSel = FLT_ABSENT;
      end else if (!descCodeData) begin
        faultSel = FLT_SYSTEM;
      end else if (overLimit) begin
        faultSel = FLT_LIMIT;
      end
    end
  end

  always_comb begin
    strobe.capture  = reqValid;
    strobe.useProt  = reqProt;
    strobe.zeroAddr = (faultSel != FLT_NONE);
    strobe.fault    = reqValid ? faultSel : FLT_NONE;
  end

endmodule

// File: rtl/segx_datapath.sv
module segx_datapath
  import segx_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  xlate_strobe_t strobe,
  input  logic [15:0]   reqSeg,
  input  logic [31:0]   reqOffset,
  input  logic [31:0]   descBase,
  input  logic [19:0]   descLimit,
  input  logic          descGran,
  output logic          overLimit,
  output logic          outValid,
  output logic [31:0]   outAddr,
  output logic [2:0]    outFault
);

  logic [31:0] effLimit;
  logic [31:0] realAddr;
  logic [31:0] protAddr;
  logic [31:0] nextAddr;

  assign effLimit  = descGran ? {descLimit, 12'hFFF} : {12'h000, descLimit};
  assign overLimit = (reqOffset > effLimit);
  assign realAddr  = {12'h000, reqSeg, 4'h0} + {16'h0000, reqOffset[15:0]};
  assign protAddr  = descBase + reqOffset;

  always_comb begin
    if (strobe.zeroAddr) begin
      nextAddr = '0;
    end else if (strobe.useProt) begin
      nextAddr = protAddr;
    end else begin
      nextAddr = realAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outAddr  <= '0;
      outFault <= '0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        outAddr  <= nextAddr;
        outFault <= strobe.fault;
      end else begin
        outAddr  <= '0;
        outFault <= '0;
      end
    end
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import segx_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqProt,
  input  logic [15:0]      reqSeg,
  input  logic [31:0]      reqOffset,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIndex,
  input  logic [31:0]      wrBase,
  input  logic [19:0]      wrLimit,
  input  logic             wrGran,
  input  logic             wrPresent,
  input  logic             wrCodeData,
  output logic             outValid,
  output logic [31:0]      outAddr,
  output logic [2:0]       outFault
);

  localparam int SEL_IDX_W = 13;

  seg_desc_t     wrDesc;
  seg_desc_t     rdDesc;
  logic          rdInRange;
  logic          overLimit;
  xlate_strobe_t strobe;

  assign wrDesc = '{base: wrBase, limit: wrLimit, gran: wrGran,
                    present: wrPresent, codeData: wrCodeData};

  segx_desc_table #(
    .NUM_DESC (NUM_DESC),
    .IDX_W    (IDX_W),
    .SEL_IDX_W(SEL_IDX_W)
  ) u_table (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrIndex  (wrIndex),
    .wrDesc   (wrDesc),
    .rdIndex  (reqSeg[15:3]),
    .rdInRange(rdInRange),
    .rdDesc   (rdDesc)
  );

  segx_ctrl u_ctrl (
    .reqValid    (reqValid),
    .reqProt     (reqProt),
    .selInRange  (rdInRange),
    .descPresent (rdDesc.present),
    .descCodeData(rdDesc.codeData),
    .overLimit   (overLimit),
    .strobe      (strobe)
  );

  segx_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqSeg   (reqSeg),
    .reqOffset(reqOffset),
    .descBase (rdDesc.base),
    .descLimit(rdDesc.limit),
    .descGran (rdDesc.gran),
    .overLimit(overLimit),
    .outValid (outValid),
    .outAddr  (outAddr),
    .outFault (outFault)
  );

endmodule

// File: rtl/seg_xlate_checks.sv
module seg_xlate_checks #(
  parameter int NUM_DESC = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqProt,
  input logic [15:0] reqSeg,
  input logic [31:0] reqOffset,
  input logic        outValid,
  input logic [31:0] outAddr,
  input logic [2:0]  outFault
);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);

  p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!outValid && outFault == 3'd0));

  p_real_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqProt) |=>
      (outAddr == ({12'h000, $past(reqSeg), 4'h0} + {16'h0000, $past(reqOffset[15:0])})));

  p_real_nofault_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqProt) |=> (outFault == 3'd0));

  p_sel_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqProt && (reqSeg[15:3] >= 13'(NUM_DESC))) |=> (outFault == 3'd1));

  p_fault_zero_addr_r11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFault != 3'd0) |-> (outAddr == 32'h0));

  p_fault_code_legal_r11: assert property (@(posedge clk) disable iff (!rstN)
    outFault <= 3'd4);

endmodule

bind seg_xlate_unit seg_xlate_checks #(.NUM_DESC(NUM_DESC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqProt  (reqProt),
  .reqSeg   (reqSeg),
  .reqOffset(reqOffset),
  .outValid (outValid),
  .outAddr  (outAddr),
  .outFault (outFault)
);

// File: tb/seg_xlate_unit_tb.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb;

  localparam int ND = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqProt = 1'b0;
  logic [15:0]   reqSeg = '0;
  logic [31:0]   reqOffset = '0;
  logic          wrEn = 1'b0;
  logic [IW-1:0] wrIndex = '0;
  logic [31:0]   wrBase = '0;
  logic [19:0]   wrLimit = '0;
  logic          wrGran = 1'b0;
  logic          wrPresent = 1'b0;
  logic          wrCodeData = 1'b0;
  logic          outValid;
  logic [31:0]   outAddr;
  logic [2:0]    outFault;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  logic [31:0] mBase [ND];
  logic [19:0] mLimit [ND];
  logic        mGran [ND];
  logic        mPres [ND];
  logic        mCd [ND];

  always #2.5 clk = ~clk;

  seg_xlate_unit #(.NUM_DESC(ND)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqProt(reqProt),
    .reqSeg(reqSeg), .reqOffset(reqOffset), .wrEn(wrEn), .wrIndex(wrIndex),
    .wrBase(wrBase), .wrLimit(wrLimit), .wrGran(wrGran), .wrPresent(wrPresent),
    .wrCodeData(wrCodeData), .outValid(outValid), .outAddr(outAddr), .outFault(outFault)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [34:0] model(input logic prot, input logic [15:0] seg,
                                        input logic [31:0] off);
    logic [2:0]  f;
    logic [31:0] a;
    logic [31:0] lim;
    int          idx;
    f = 3'd0;
    a = 32'h0;
    if (!prot) begin
      a = {12'h0, seg, 4'h0} + {16'h0, off[15:0]};
    end else begin
      idx = int'(seg[15:3]);
      if (idx >= ND) f = 3'd1;
      else if (!mPres[idx]) f = 3'd2;
      else if (!mCd[idx]) f = 3'd3;
      else begin
        lim = mGran[idx] ? {mLimit[idx], 12'hFFF} : {12'h0, mLimit[idx]};
        if (off > lim) f = 3'd4;
        else a = mBase[idx] + off;
      end
    end
    return {f, a};
  endfunction

  function automatic string tagFor(input logic prot, input logic [2:0] f);
    if (!prot) return "R3";
    case (f)
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8/R9";
      default: return "R4";
    endcase
  endfunction

  // Apply one cycle at a negedge; outputs checked at the following negedge.
  task automatic vec(input logic rv, input logic prot, input logic [15:0] seg,
                     input logic [31:0] off, input logic we, input int wi,
                     input logic [31:0] wb, input logic [19:0] wl, input logic wg,
                     input logic wp, input logic wc, input string tag);
    logic [34:0] e;
    reqValid = rv; reqProt = prot; reqSeg = seg; reqOffset = off;
    wrEn = we; wrIndex = IW'(wi); wrBase = wb; wrLimit = wl;
    wrGran = wg; wrPresent = wp; wrCodeData = wc;
    e = model(prot, seg, off);
    @(posedge clk);
    if (we) begin
      mBase[wi] = wb; mLimit[wi] = wl; mGran[wi] = wg; mPres[wi] = wp; mCd[wi] = wc;
    end
    @(negedge clk);
    reqValid = 1'b0; wrEn = 1'b0;
    if (rv) begin
      check({tag, " valid R2"}, 32'(outValid), 32'd1);
      check({tag, " fault"}, 32'(outFault), 32'(e[34:32]));
      check({tag, " addr R11"}, outAddr, e[31:0]);
    end else begin
      check({tag, " idle R2"}, 32'(outValid), 32'd0);
      check({tag, " idle fault R2"}, 32'(outFault), 32'd0);
    end
  endtask

  task automatic wr(input int wi, input logic [31:0] wb, input logic [19:0] wl,
                    input logic wg, input logic wp, input logic wc);
    vec(1'b0, 1'b0, 16'h0, 32'h0, 1'b1, wi, wb, wl, wg, wp, wc, "write");
  endtask

  task automatic rq(input logic prot, input logic [15:0] seg, input logic [31:0] off,
                    input string tag);
    vec(1'b1, prot, seg, off, 1'b0, 0, 32'h0, 20'h0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ND; i++) begin
      mBase[i] = '0; mLimit[i] = '0; mGran[i] = 0; mPres[i] = 0; mCd[i] = 0;
    end
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 valid", 32'(outValid), 32'd0);
    check("R1 fault", 32'(outFault), 32'd0);
    check("R1 addr", outAddr, 32'd0);
    rq(1'b1, 16'h0000, 32'h0, "R1 entry absent after reset");

    // R3: real mode, overlapping segments, carry past bit 19, upper offset ignored
    rq(1'b0, 16'h1000, 32'h0000_FFFF, "R3 seg1000");
    rq(1'b0, 16'h1010, 32'h0000_FFFF, "R3 seg1010 top");
    rq(1'b0, 16'hFFFF, 32'h0000_FFFF, "R3 no wrap");
    rq(1'b0, 16'h0123, 32'hABCD_0010, "R3 upper offset ignored");

    // R8: byte granularity boundaries
    wr(0, 32'h0010_0000, 20'h00FFF, 1'b0, 1'b1, 1'b1);
    rq(1'b1, 16'h0000, 32'h0000_0FFF, "R8 at limit");
    rq(1'b1, 16'h0000, 32'h0000_1000, "R8 past limit");
    rq(1'b1, 16'h0007, 32'h0000_0010, "R5 low selector bits ignored");

    // R9: page granularity
    wr(1, 32'h4000_0000, 20'h00002, 1'b1, 1'b1, 1'b1);
    rq(1'b1, 16'h0008, 32'h0000_2FFF, "R9 at scaled limit");
    rq(1'b1, 16'h0008, 32'h0000_3000, "R9 past scaled limit");

    // R7/R10: system entry beyond its limit reports system
    wr(2, 32'h0000_1000, 20'h00010, 1'b0, 1'b1, 1'b0);
    rq(1'b1, 16'h0010, 32'h0000_0100, "R7 R10 system over limit");
    // R6/R10: absent system entry reports absent
    wr(3, 32'h0000_2000, 20'h00010, 1'b0, 1'b0, 1'b0);
    rq(1'b1, 16'h0018, 32'h0000_0100, "R6 R10 absent");
    // R5: index equal to table size
    rq(1'b1, 16'h0040, 32'h0, "R5 index past table");
    rq(1'b1, 16'hFFFF, 32'h0, "R5 max selector");

    // R4: base wraps modulo 2^32
    wr(4, 32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b1, 1'b1);
    rq(1'b1, 16'h0020, 32'h0000_2000, "R4 wrap");
    rq(1'b1, 16'h0020, 32'hFFFF_FFFF, "R4 full offset");

    // R12: write in the same cycle as a request uses the old entry
    wr(5, 32'h0AAA_0000, 20'h0FFFF, 1'b0, 1'b1, 1'b1);
    vec(1'b1, 1'b1, 16'h0028, 32'h0000_0004, 1'b1, 5, 32'h0BBB_0000, 20'h0FFFF,
        1'b0, 1'b1, 1'b1, "R12 same-cycle write");
    check("R12 old base used", outAddr, 32'h0AAA_0004);
    rq(1'b1, 16'h0028, 32'h0000_0004, "R12 new base");
    check("R12 new base used", outAddr, 32'h0BBB_0004);

    // R2: idle cycle
    vec(1'b0, 1'b1, 16'h0000, 32'h0, 1'b0, 0, 32'h0, 20'h0, 1'b0, 1'b0, 1'b0, "R2 idle");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic        prot, we, rv;
      logic [15:0] seg;
      logic [31:0] off;
      int          wi;
      logic [2:0]  ef;
      logic [34:0] e;
      prot = 1'($urandom);
      rv   = ($urandom % 8) != 0;
      we   = ($urandom % 4) == 0;
      wi   = int'($urandom % ND);
      seg  = {13'($urandom % 10), 3'($urandom)};
      if (!prot) seg = 16'($urandom);
      case ($urandom % 3)
        0: off = $urandom;
        1: off = {12'h0, 20'($urandom)};
        default: off = {20'($urandom % 4), 12'hFFF} + 32'($urandom % 2);
      endcase
      e  = model(prot, seg, off);
      ef = e[34:32];
      vec(rv, prot, seg, off, we, wi, $urandom, 20'($urandom % 4), 1'($urandom),
          ($urandom % 6) != 0, ($urandom % 6) != 0, {"rand ", tagFor(prot, ef)});
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule